// File: doc/BRIEF.md
# Multiplexed External Bus Controller

This block is the bus interface unit of a small 8-bit microcontroller core. It runs every external program fetch and every external data read or write over a shared port. That port carries the low address byte first and the data byte after it. A separate port carries the high address byte. An address-latch pulse rises at the start of every machine cycle, whether or not an access is running. An external transparent latch holds the low address byte on the falling edge of that pulse.

The core raises `req_i` with an address, a write flag, a fetch flag, the write byte and a wait count. The request is held until `done_o` pulses for one clock. `done_o` returns the read byte on `rdata_o`.

Program fetches use their own active-low strobe, which pulses twice in the fetch cycle. Data accesses use active-low read and write strobes. A strap input chooses where fetches go. When the strap is high, a fetch is handed to internal memory and the external bus stays quiet. A wait count of 0 to 7 lengthens the final strobe clock of the cycle for slow memories. The machine cycle grows by the same number of clocks.

Top module: `xbus_ctrl`

## Requirements

Clocks of a machine cycle are numbered from 1, and clock 1 is the first clock with `ale_o` high.

- R1: While `rst_ni` is low, `ale_o` is low, `psen_no`, `rd_no` and `wr_no` are high, `ad_oe_o` is low, `done_o` is low and `rdata_o` is zero.
- R2: `ale_o` is high on clocks 1 and 2 of every machine cycle and low on the other clocks. With no request pending, a machine cycle lasts six clocks and `ale_o` keeps pulsing.
- R3: During clocks 1 and 2 of an external access, `ad_oe_o` is high and `ad_o` equals `addr_i[7:0]`. `ahi_o` equals `addr_i[15:8]` for the whole access.
- R4: Read (`fetch_i`=0, `we_i`=0): `ad_oe_o` is low from clock 3 onward. `rd_no` is low on clocks 4 and 5, and clock 5 is repeated w more times. `psen_no` and `wr_no` stay high.
- R5: Write (`fetch_i`=0, `we_i`=1): `ad_o` carries the write byte with `ad_oe_o` high from clock 3 through the last clock of the cycle. That last clock is the first clock after `wr_no` rises. `wr_no` is low on clocks 4 and 5, and clock 5 is stretched by w.
- R6: Fetch with `ext_code_ni` low: `psen_no` is low alone on clock 3, high on clock 4, and low again on clock 5, which is stretched by w. `ad_oe_o` is low from clock 3 onward. `rd_no` and `wr_no` stay high.
- R7: Fetch with `ext_code_ni` high: no strobe falls and `ad_oe_o` stays low. `done_o` comes with `int_fetch_o` high and `rdata_o` zero. `int_fetch_o` is low for every other kind of access.
- R8: For a read or an external fetch, `rdata_o` at `done_o` equals `ad_i` as it was on the final strobe clock. A write returns zero.
- R9: A request is taken only on the last clock of an idle machine cycle, and it is never taken on a clock where `done_o` is high. The access fills the next machine cycle. `done_o` is high for exactly one clock, the last clock of that cycle.
- R10: At most one of `psen_no`, `rd_no` and `wr_no` is low at any time, and none of them is low while `ale_o` is high.
- R11: `wait_i` (0 to 7) is captured with the request. An external access cycle lasts 6 + w clocks. An internal fetch cycle lasts 6 clocks.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, held until done |
| addr_i | input | 16 | Access address |
| we_i | input | 1 | 1 = write (data accesses only) |
| fetch_i | input | 1 | 1 = program fetch, 0 = data access |
| wdata_i | input | 8 | Write byte |
| wait_i | input | 3 | Wait count for this access |
| ext_code_ni | input | 1 | Strap: low sends all fetches to external memory |
| done_o | output | 1 | One-clock completion pulse |
| rdata_o | output | 8 | Read byte, valid with done_o |
| int_fetch_o | output | 1 | Completion belongs to an internal fetch |
| ale_o | output | 1 | Address latch pulse |
| psen_no | output | 1 | Program fetch strobe, active low |
| rd_no | output | 1 | Data read strobe, active low |
| wr_no | output | 1 | Data write strobe, active low |
| ad_o | output | 8 | Shared port, outgoing value |
| ad_i | input | 8 | Shared port, incoming value |
| ad_oe_o | output | 1 | Shared port drive enable |
| ahi_o | output | 8 | High address byte port |

## Verification

The hardest case to reach from the ports is a stretched strobe whose data is valid on only one clock. The bench's memory model drives a real value only while a strobe is low and a filler value otherwise. This means a sample taken one clock late, or on the wrong clock of a stretch, returns the wrong byte.

Requests are raised at every offset inside the free-running machine cycle. The bench then locates the access from the `done_o` clock and checks every pin on every clock, for all four access kinds and all eight wait counts. One case keeps `req_i` high through the `done_o` clock, to show that the request is not taken a second time.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  typedef enum logic [1:0] {
    XK_READ      = 2'd0,
    XK_WRITE     = 2'd1,
    XK_FETCH_EXT = 2'd2,
    XK_FETCH_INT = 2'd3
  } xkind_e;

  localparam int unsigned PH_W = 3;
  typedef logic [PH_W-1:0] phase_t;

  // sub-state positions inside one machine cycle
  localparam phase_t PH_ALE0    = 3'd0;
  localparam phase_t PH_TURN    = 3'd2;
  localparam phase_t PH_STB     = 3'd3;
  localparam phase_t PH_STRETCH = 3'd4;
  localparam phase_t PH_LAST    = 3'd5;
endpackage

// File: rtl/xbus_phase.sv
module xbus_phase
  import xbus_pkg::*;
#(
  parameter int unsigned WAIT_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stretch_en_i,
  input  logic [WAIT_W-1:0] wait_i,
  output phase_t            phase_o,
  output logic              last_strobe_o,
  output logic              cycle_end_o
);
  logic [WAIT_W-1:0] wcnt_q;
  logic              hold;

  assign hold          = stretch_en_i && (phase_o == PH_STRETCH) && (wcnt_q != wait_i);
  assign last_strobe_o = (phase_o == PH_STRETCH) && !hold;
  assign cycle_end_o   = (phase_o == PH_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_o <= PH_LAST;
      wcnt_q  <= '0;
    end else if (hold) begin
      wcnt_q  <= wcnt_q + 1'b1;
    end else begin
      wcnt_q  <= '0;
      phase_o <= (phase_o == PH_LAST) ? PH_ALE0 : phase_o + 3'd1;
    end
  end

  a_r11_freeze_on_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold |=> (phase_o == PH_STRETCH));
  a_r11_wait_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == PH_STRETCH) |-> (wcnt_q <= wait_i));
  a_r2_cycle_wraps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cycle_end_o |=> (phase_o == PH_ALE0));
endmodule

// File: rtl/xbus_req.sv
module xbus_req
  import xbus_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned WAIT_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cycle_end_i,
  input  logic              last_strobe_i,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic              fetch_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [WAIT_W-1:0] wait_i,
  input  logic              ext_code_ni,
  input  logic [DATA_W-1:0] ad_i,
  output logic              active_o,
  output xkind_e            kind_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [WAIT_W-1:0] wait_o,
  output logic [DATA_W-1:0] rdata_o
);
  xkind_e kind_d;
  logic   samples;

  always_comb begin
    if (fetch_i)   kind_d = ext_code_ni ? XK_FETCH_INT : XK_FETCH_EXT;
    else if (we_i) kind_d = XK_WRITE;
    else           kind_d = XK_READ;
  end

  assign samples = active_o && last_strobe_i &&
                   (kind_o == XK_READ || kind_o == XK_FETCH_EXT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      kind_o   <= XK_READ;
      addr_o   <= '0;
      wdata_o  <= '0;
      wait_o   <= '0;
      rdata_o  <= '0;
    end else if (cycle_end_i) begin
      if (active_o) begin
        active_o <= 1'b0;
      end else if (req_i) begin
        active_o <= 1'b1;
        kind_o   <= kind_d;
        addr_o   <= addr_i;
        wdata_o  <= wdata_i;
        wait_o   <= (kind_d == XK_FETCH_INT) ? '0 : wait_i;
        rdata_o  <= '0;
      end
    end else if (samples) begin
      rdata_o <= ad_i;
    end
  end

  a_r9_fields_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && !cycle_end_i) |=> ($stable(addr_o) && $stable(kind_o) && $stable(wait_o)));
  a_r9_one_cycle_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && cycle_end_i) |=> !active_o);
endmodule

// File: rtl/xbus_pins.sv
module xbus_pins
  import xbus_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned HI_W = ADDR_W - DATA_W
) (
  input  logic              active_i,
  input  xkind_e            kind_i,
  input  phase_t            phase_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ale_o,
  output logic              psen_no,
  output logic              rd_no,
  output logic              wr_no,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  output logic [HI_W-1:0]   ahi_o
);
  logic addr_ph, strobe_ph, ext;

  assign addr_ph   = phase_i < PH_TURN;
  assign strobe_ph = (phase_i == PH_STB) || (phase_i == PH_STRETCH);
  assign ext       = active_i && (kind_i != XK_FETCH_INT);

  assign ale_o   = addr_ph;
  assign ad_oe_o = ext && (addr_ph || kind_i == XK_WRITE);
  assign ad_o    = addr_ph ? addr_i[DATA_W-1:0] : wdata_i;
  assign ahi_o   = addr_i[ADDR_W-1:DATA_W];

  assign rd_no   = !(active_i && kind_i == XK_READ  && strobe_ph);
  assign wr_no   = !(active_i && kind_i == XK_WRITE && strobe_ph);
  // fetch strobe pulses twice: turnaround clock, then the stretchable clock
  assign psen_no = !(active_i && kind_i == XK_FETCH_EXT &&
                     (phase_i == PH_TURN || phase_i == PH_STRETCH));
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned WAIT_W = 3,
  localparam int unsigned HI_W = ADDR_W - DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic              fetch_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [WAIT_W-1:0] wait_i,
  input  logic              ext_code_ni,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              int_fetch_o,
  output logic              ale_o,
  output logic              psen_no,
  output logic              rd_no,
  output logic              wr_no,
  output logic [DATA_W-1:0] ad_o,
  input  logic [DATA_W-1:0] ad_i,
  output logic              ad_oe_o,
  output logic [HI_W-1:0]   ahi_o
);
  phase_t            phase;
  logic              last_strobe, cycle_end, active;
  xkind_e            kind;
  logic [ADDR_W-1:0] acc_addr;
  logic [DATA_W-1:0] acc_wdata;
  logic [WAIT_W-1:0] acc_wait;

  xbus_phase #(.WAIT_W(WAIT_W)) u_phase (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .stretch_en_i (active && kind != XK_FETCH_INT),
    .wait_i       (acc_wait),
    .phase_o      (phase),
    .last_strobe_o(last_strobe),
    .cycle_end_o  (cycle_end)
  );

  xbus_req #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAIT_W(WAIT_W)) u_req (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cycle_end_i  (cycle_end),
    .last_strobe_i(last_strobe),
    .req_i        (req_i),
    .addr_i       (addr_i),
    .we_i         (we_i),
    .fetch_i      (fetch_i),
    .wdata_i      (wdata_i),
    .wait_i       (wait_i),
    .ext_code_ni  (ext_code_ni),
    .ad_i         (ad_i),
    .active_o     (active),
    .kind_o       (kind),
    .addr_o       (acc_addr),
    .wdata_o      (acc_wdata),
    .wait_o       (acc_wait),
    .rdata_o      (rdata_o)
  );

  xbus_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .active_i(active),
    .kind_i  (kind),
    .phase_i (phase),
    .addr_i  (acc_addr),
    .wdata_i (acc_wdata),
    .ale_o   (ale_o),
    .psen_no (psen_no),
    .rd_no   (rd_no),
    .wr_no   (wr_no),
    .ad_o    (ad_o),
    .ad_oe_o (ad_oe_o),
    .ahi_o   (ahi_o)
  );

  assign done_o      = active && cycle_end;
  assign int_fetch_o = done_o && (kind == XK_FETCH_INT);

  a_r10_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({!psen_no, !rd_no, !wr_no}) <= 1);
  a_r10_quiet_in_ale: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> (psen_no && rd_no && wr_no));
  a_r2_ale_two_clocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ale_o) |=> (ale_o ##1 !ale_o));
  a_r4_released_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_no || !psen_no) |-> !ad_oe_o);
  a_r5_write_setup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wr_no) |-> $past(ad_oe_o));
  a_r5_write_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_no) |-> ad_oe_o);
  a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r7_internal_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_fetch_o |-> (psen_no && !ad_oe_o));
endmodule

// File: tb/xbus_ctrl_test.sv
`timescale 1ns/1ps
module xbus_ctrl_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_ni, req, we, fetch, ext_code_n;
  logic [15:0] addr;
  logic [7:0]  wdata, rdata, ad_o, ad_i, ahi;
  logic [2:0]  wait_n;
  logic        done, int_fetch, ale, psen_n, rd_n, wr_n, ad_oe;

  int n_chk = 0;
  int n_fail = 0;

  xbus_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .addr_i(addr), .we_i(we),
    .fetch_i(fetch), .wdata_i(wdata), .wait_i(wait_n), .ext_code_ni(ext_code_n),
    .done_o(done), .rdata_o(rdata), .int_fetch_o(int_fetch), .ale_o(ale),
    .psen_no(psen_n), .rd_no(rd_n), .wr_no(wr_n), .ad_o(ad_o), .ad_i(ad_i),
    .ad_oe_o(ad_oe), .ahi_o(ahi)
  );

  function automatic logic [7:0] mem_f(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  // external latch and memory model: real data only while a strobe is low
  logic [7:0] lat = 8'h00;
  always @(negedge clk) if (ale) lat <= ad_o;
  assign ad_i = (!rd_n || !psen_n) ? mem_f({ahi, lat}) : 8'hEE;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic string kind_tag(input int k);
    case (k)
      0: return "R4 read";
      1: return "R5 write";
      2: return "R6 ext fetch";
      default: return "R7 int fetch";
    endcase
  endfunction

  // kind: 0 read, 1 write, 2 external fetch, 3 internal fetch
  task automatic do_access(input int kind, input logic [15:0] a,
                           input logic [7:0] wd, input int w, input bit keep_req);
    logic [4:0] obs [64];
    logic [7:0] lo_seen = 8'h00, hi_seen = 8'h00, wr_seen = 8'h00, got = 8'h00;
    logic       intf = 1'b0;
    int d = -1;
    int weff, s, bad, bad_act, bad_exp;
    bit ext;
    ext  = (kind != 3);
    weff = ext ? w : 0;
    @(negedge clk);
    req = 1'b1; addr = a; we = (kind == 1); fetch = (kind >= 2);
    wdata = wd; wait_n = w[2:0]; ext_code_n = (kind == 3);
    for (int j = 0; j < 64; j++) begin
      if (j > 0) @(negedge clk);
      obs[j] = {ale, psen_n, rd_n, wr_n, ad_oe};
      if (ale && ad_oe) lo_seen = ad_o;
      if (ale) hi_seen = ahi;
      if (!wr_n && ad_oe) wr_seen = ad_o;
      if (done) begin
        d = j; got = rdata; intf = int_fetch;
        break;
      end
    end
    if (!keep_req) req = 1'b0;
    chk(d >= 0, "R9 done seen", d, 1);
    if (d < 0) return;
    s = d - 6 - weff;
    chk(s >= 0 && s < 6, "R9 accepted at cycle boundary", s, 0);
    if (s < 0) return;
    bad = 0; bad_act = 0; bad_exp = 0;
    for (int j = 0; j <= d; j++) begin
      logic [4:0] e;
      int p, jj;
      if (j < s) begin
        e = {obs[j][4], 4'b1110};
      end else begin
        jj = j - s;
        if (jj == 0) p = 5;
        else if (jj <= 4) p = jj - 1;
        else if (jj <= 5 + weff) p = 4;
        else p = 5;
        if (jj == 0) e = {1'b0, 4'b1110};
        else e = {p < 2,
                  !(kind == 2 && (p == 2 || p == 4)),
                  !(kind == 0 && (p == 3 || p == 4)),
                  !(kind == 1 && (p == 3 || p == 4)),
                  ext && (p < 2 || kind == 1)};
      end
      if (obs[j] !== e && bad == 0) begin
        bad = 1; bad_act = {j, 3'b0, obs[j]}; bad_exp = {j, 3'b0, e};
      end
    end
    // per-clock pin pattern: R2 ALE, R9 placement, R11 stretch length
    chk(bad == 0, {kind_tag(kind), " pins R2 R9 R11"}, bad_act, bad_exp);
    if (ext) begin
      chk(lo_seen == a[7:0] && hi_seen == a[15:8], "R3 address bytes",
          {hi_seen, lo_seen}, a);
    end
    case (kind)
      0, 2: chk(got == mem_f(a), "R8 read data", got, mem_f(a));
      1: begin
        chk(wr_seen == wd, "R5 write data", wr_seen, wd);
        chk(got == 8'h00, "R8 write returns zero", got, 0);
      end
      default: chk(got == 8'h00, "R7 internal fetch data", got, 0);
    endcase
    chk(intf == (kind == 3), "R7 int_fetch flag", intf, kind == 3);
    @(negedge clk);
    chk(!done, "R9 done one clock", done, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int first;
    bit okp;
    rst_ni = 1'b0; req = 1'b0; addr = '0; we = 1'b0; fetch = 1'b0;
    wdata = '0; wait_n = '0; ext_code_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!ale && psen_n && rd_n && wr_n && !ad_oe, "R1 reset pins",
        {ale, psen_n, rd_n, wr_n, ad_oe}, 5'b01110);
    chk(!done && rdata == 8'h00, "R1 reset done/rdata", {done, rdata}, 0);
    rst_ni = 1'b1;

    // R2: idle ALE pulses every six clocks, two clocks high
    first = -1; okp = 1'b1;
    for (int j = 0; j < 30; j++) begin
      @(negedge clk);
      if (first < 0 && ale) first = j;
      if (first >= 0 && ale !== (((j - first) % 6) < 2)) okp = 1'b0;
      if (!psen_n || !rd_n || !wr_n || ad_oe) okp = 1'b0;
    end
    chk(okp && first >= 0 && first < 6, "R2 idle ALE cadence", first, 0);

    // sweep every kind and wait count, at varied alignments (R11)
    for (int k = 0; k < 4; k++)
      for (int w = 0; w < 8; w++)
        for (int ai = 0; ai < 2; ai++) begin
          logic [15:0] a;
          a = 16'h1234 + 16'(k * 16'h0911) + 16'(w * 16'h0137);
          if (ai == 1) a = ~a;
          repeat ((k + w + ai) % 6) @(negedge clk);
          do_access(k, a, a[7:0] ^ 8'hA5 ^ 8'(w), w, 1'b0);
        end

    // R9: request still high on the done clock is not taken again
    do_access(0, 16'hBEEF, 8'h00, 2, 1'b1);
    req = 1'b0;
    okp = 1'b1;
    for (int j = 0; j < 8; j++) begin
      @(negedge clk);
      if (!rd_n || !psen_n || !wr_n || ad_oe || done) okp = 1'b0;
    end
    chk(okp, "R9 no re-accept on done clock", okp, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule